// File: doc/BRIEF.md
# I2C Target Protocol Engine

This block is the bus-facing half of an I2C target. It watches the serial clock and data lines through synchronizers. It picks out START and STOP conditions and collects the 7-bit address with its direction bit. It answers only when the address equals the value on its `own_addr` input. After a match it either takes bytes from the controller or sends bytes to it, one byte at a time. Each byte is acknowledged or checked for acknowledge on the ninth clock.

The local side sees each received byte as a one-cycle `rx_valid` strobe with the byte on `rx_data`. When a byte must be sent, the engine takes `tx_data` if `tx_valid` is high and pulses `tx_take`; otherwise it sends a fill byte. One-cycle event pulses mark bus START, bus STOP, a read request for the own address, and the end of a read, which the controller signals by not acknowledging. The data line is open-drain: `sda_oe` high means "pull the line low". Clock stretching, 10-bit addressing, general call and high-speed mode are not provided.

Top module: `i2cs_target`

## Requirements
- R1: A START (SDA falls while SCL is high) gives one `ev_start` pulse and a STOP (SDA rises while SCL is high) gives one `ev_stop` pulse, whatever the address; SDA edges while SCL is low give neither.
- R2: The first byte after START is taken MSB first as 7 address bits then a direction bit (0 = controller writes, 1 = controller reads); only when the address equals `own_addr` does the target pull SDA low through the ninth clock.
- R3: In a write, each received byte appears MSB first on `rx_data` with exactly one `rx_valid` pulse, and the target pulls SDA low on its ninth clock.
- R4: A matching address with direction 1 gives exactly one `ev_rd_req` pulse, and a matching write address gives none.
- R5: In a read, bytes go out MSB first; each byte is `tx_data` when `tx_valid` is high at load time, with one `tx_take` pulse, and otherwise the fill byte 8'hFF with no pulse; a further byte follows each controller acknowledge (SDA low on the ninth clock).
- R6: When the controller leaves SDA high on the ninth clock of a sent byte, one `ev_done` pulse is produced and the target releases SDA until the next START or STOP.
- R7: A repeated START in the middle of a transfer returns the engine to address reception without a STOP in between.
- R8: After a non-matching address SDA stays released and no `rx_valid` pulse is produced until the next START or STOP.
- R9: `sda_oe` changes only while the synchronized SCL is low, except on a START or STOP, and the data line is only ever pulled low.
- R10: After reset `sda_oe` is low and no event or strobe output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| own_addr | input | 7 | Address this target answers to |
| sda_oe | output | 1 | High pulls the data line low |
| tx_data | input | 8 | Byte to send on the next load |
| tx_valid | input | 1 | `tx_data` holds a byte ready to send |
| tx_take | output | 1 | One-cycle pulse: `tx_data` was loaded |
| rx_data | output | 8 | Last byte received from the controller |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| ev_start | output | 1 | One-cycle pulse per bus START |
| ev_stop | output | 1 | One-cycle pulse per bus STOP |
| ev_rd_req | output | 1 | One-cycle pulse: own address with read direction |
| ev_done | output | 1 | One-cycle pulse: controller did not acknowledge a sent byte |

## Verification
The bench builds the engine with its default parameters: a two-stage synchronizer and the fill byte 8'hFF. It sets `own_addr` to 7'h31 and drives a bit-banged controller whose quarter-bit time is 10 system clocks. That spacing leaves room for the synchronizer and detector latency before each SCL edge. So the bench can check acknowledge levels, data bits and the open-drain line in the middle of each high phase. It also reaches the fill-byte path by dropping `tx_valid` during a read. It reaches the ignore path through a non-matching address and the repeated-START path through a write followed by a read with no STOP between them.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_TACK,
    ST_IGNORE
  } eng_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic det_start,
  output logic det_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      scl_lvl   <= 1'b1;
      sda_lvl   <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      det_start <= 1'b0;
      det_stop  <= 1'b0;
    end else begin
      scl_q     <= scl_s;
      sda_q     <= sda_s;
      scl_lvl   <= scl_s;
      sda_lvl   <= sda_s;
      scl_rise  <= scl_s & ~scl_q;
      scl_fall  <= ~scl_s & scl_q;
      det_start <= scl_s & scl_q & sda_q & ~sda_s;
      det_stop  <= scl_s & scl_q & ~sda_q & sda_s;
    end
  end

  // R1: a bus condition is either a START or a STOP, never both at once
  a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(det_start && det_stop));

  // R1: conditions only come while SCL is high, so no clock edge comes with them
  a_r1_cond_scl_high: assert property (@(posedge clk) disable iff (rst)
    (det_start || det_stop) |-> (scl_lvl && !scl_rise && !scl_fall));
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_FILL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              det_start,
  input  logic              det_stop,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              sda_oe,
  output logic              tx_take,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ev_rd_req,
  output logic              ev_done
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw;
  logic              phase;
  logic [BYTE_W-1:0] nxt_byte;

  assign nxt_byte = tx_valid ? tx_data : IDLE_FILL;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rw        <= 1'b0;
      phase     <= 1'b0;
      sda_oe    <= 1'b0;
      tx_take   <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      ev_rd_req <= 1'b0;
      ev_done   <= 1'b0;
    end else begin
      tx_take   <= 1'b0;
      rx_valid  <= 1'b0;
      ev_rd_req <= 1'b0;
      ev_done   <= 1'b0;
      if (det_start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        phase  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (det_stop) begin
        state  <= ST_IDLE;
        phase  <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (sh[ADDR_W-1:0] == own_addr) begin
                rw        <= sda_lvl;
                ev_rd_req <= sda_lvl;
                state     <= ST_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!phase) begin
              sda_oe <= 1'b1;
              phase  <= 1'b1;
            end else begin
              phase <= 1'b0;
              cnt   <= '0;
              if (rw) begin
                sh      <= nxt_byte;
                sda_oe  <= ~nxt_byte[BYTE_W-1];
                tx_take <= tx_valid;
                state   <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX: if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              rx_data  <= {sh[BYTE_W-2:0], sda_lvl};
              rx_valid <= 1'b1;
              state    <= ST_ACK;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_TACK;
            end else begin
              cnt    <= cnt + 1'b1;
              sh     <= {sh[BYTE_W-2:0], 1'b1};
              sda_oe <= ~sh[BYTE_W-2];
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              if (sda_lvl) begin
                ev_done <= 1'b1;
                state   <= ST_IGNORE;
              end else begin
                phase <= 1'b1;
              end
            end else if (scl_fall && phase) begin
              phase   <= 1'b0;
              cnt     <= '0;
              sh      <= nxt_byte;
              sda_oe  <= ~nxt_byte[BYTE_W-1];
              tx_take <= tx_valid;
              state   <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the pull-down changes only in a cycle that follows SCL seen low, unless a bus condition caused it
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(det_start) && !$past(det_stop)) |-> !$past(scl_lvl));

  // R6: after the end-of-read pulse the line stays released
  a_r6_done_releases: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> !sda_oe);

  // R4: read request, received byte and end of read never coincide
  a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_rd_req, rx_valid, ev_done, tx_take}));

  // R3: a received byte is followed by the acknowledge pull-down at the next SCL fall
  a_r3_ack_after_byte: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && phase && !det_start && !det_stop && !scl_fall) |=> sda_oe);
endmodule

// File: rtl/i2cs_target.sv
module i2cs_target
  import i2cs_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] IDLE_FILL   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_take,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              ev_rd_req,
  output logic              ev_done
);
  logic [1:0] pins_s;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (pins_s)
  );

  i2cs_cond_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (pins_s[1]),
    .sda_s     (pins_s[0]),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .det_start (ev_start),
    .det_stop  (ev_stop)
  );

  i2cs_engine #(.IDLE_FILL(IDLE_FILL)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .det_start (ev_start),
    .det_stop  (ev_stop),
    .own_addr  (own_addr),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .sda_oe    (sda_oe),
    .tx_take   (tx_take),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .ev_rd_req (ev_rd_req),
    .ev_done   (ev_done)
  );
endmodule

// File: tb/i2cs_target_tb_top.sv
module i2cs_target_tb_top;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic tx_en = 1'b0;
  logic [7:0] tx_src [4];
  logic [7:0] tx_data;
  logic sda_oe, tx_take, rx_valid, ev_start, ev_stop, ev_rd_req, ev_done;
  logic [7:0] rx_data;
  logic sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  int n_start = 0, n_stop = 0, n_rdreq = 0, n_done = 0, n_take = 0, n_rx = 0;
  logic [7:0] rx_log [16];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign tx_data  = tx_src[n_take[1:0]];

  i2cs_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .own_addr(OWN),
    .sda_oe(sda_oe), .tx_data(tx_data), .tx_valid(tx_en), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rd_req(ev_rd_req), .ev_done(ev_done)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (ev_start)  n_start <= n_start + 1;
      if (ev_stop)   n_stop  <= n_stop + 1;
      if (ev_rd_req) n_rdreq <= n_rdreq + 1;
      if (ev_done)   n_done  <= n_done + 1;
      if (tx_take)   n_take  <= n_take + 1;
      if (rx_valid) begin
        rx_log[n_rx[3:0]] <= rx_data;
        n_rx <= n_rx + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(2);
    sda_m = 1'b0; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(2);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic bit_cycle(input logic b, output logic seen);
    sda_m = b; wq(1);
    scl_m = 1'b1; wq(1);
    seen = sda_line; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, ack);
  endtask

  task automatic get_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~m_ack, s);
  endtask

  task automatic t_reset();
    chk("R10 sda_oe after reset", int'(sda_oe), 0);
    chk("R10 pulses after reset",
        int'({ev_start, ev_stop, ev_rd_req, ev_done, rx_valid, tx_take}), 0);
  endtask

  task automatic t_write_own();
    logic a0, a1, a2;
    int s0 = n_start, p0 = n_stop, r0 = n_rx, q0 = n_rdreq;
    bus_start();
    put_byte({OWN, 1'b0}, a0);
    put_byte(8'hA5, a1);
    put_byte(8'h3C, a2);
    bus_stop();
    wq(1);
    chk("R2 address ack", int'(a0), 0);
    chk("R3 data ack byte 1", int'(a1), 0);
    chk("R3 data ack byte 2", int'(a2), 0);
    chk("R3 rx count", n_rx - r0, 2);
    chk("R3 rx byte 1", int'(rx_log[r0[3:0]]), 8'hA5);
    chk("R3 rx byte 2", int'(rx_log[r0[3:0] + 4'd1]), 8'h3C);
    chk("R1 start event", n_start - s0, 1);
    chk("R1 stop event", n_stop - p0, 1);
    chk("R4 no read request on write", n_rdreq - q0, 0);
    chk("R9 line released after write", int'(sda_oe), 0);
  endtask

  task automatic t_other_addr();
    logic a0, a1;
    int s0 = n_start, p0 = n_stop, r0 = n_rx;
    bus_start();
    put_byte({7'h52, 1'b0}, a0);
    put_byte(8'h00, a1);
    bus_stop();
    wq(1);
    chk("R8 no ack for other address", int'(a0), 1);
    chk("R8 no ack for data after other address", int'(a1), 1);
    chk("R8 no rx strobe", n_rx - r0, 0);
    chk("R1 start counted for other address", n_start - s0, 1);
    chk("R1 stop counted for other address", n_stop - p0, 1);
  endtask

  task automatic t_read();
    logic a0;
    logic [7:0] b0, b1, b2;
    int q0 = n_rdreq, d0 = n_done, k0 = n_take;
    tx_src[n_take[1:0]]        = 8'h96;
    tx_src[n_take[1:0] + 2'd1] = 8'h01;
    tx_src[n_take[1:0] + 2'd2] = 8'hE7;
    tx_en = 1'b1;
    bus_start();
    put_byte({OWN, 1'b1}, a0);
    get_byte(1'b1, b0);
    get_byte(1'b1, b1);
    get_byte(1'b0, b2);
    wq(1);
    chk("R2 read address ack", int'(a0), 0);
    chk("R4 read request", n_rdreq - q0, 1);
    chk("R5 read byte 1", int'(b0), 8'h96);
    chk("R5 read byte 2", int'(b1), 8'h01);
    chk("R5 read byte 3", int'(b2), 8'hE7);
    chk("R5 take count", n_take - k0, 3);
    chk("R6 done pulse", n_done - d0, 1);
    chk("R6 line released after nack", int'(sda_oe), 0);
    bus_stop();
    tx_en = 1'b0;
  endtask

  task automatic t_fill();
    logic a0;
    logic [7:0] b0;
    int k0 = n_take;
    tx_en = 1'b0;
    bus_start();
    put_byte({OWN, 1'b1}, a0);
    get_byte(1'b0, b0);
    bus_stop();
    chk("R5 fill byte when not valid", int'(b0), 8'hFF);
    chk("R5 no take when not valid", n_take - k0, 0);
  endtask

  task automatic t_restart();
    logic a0, a1, a2;
    logic [7:0] b0;
    int p0 = n_stop, r0 = n_rx, s0 = n_start;
    tx_src[n_take[1:0]] = 8'h5A;
    tx_en = 1'b1;
    bus_start();
    put_byte({OWN, 1'b0}, a0);
    put_byte(8'hC3, a1);
    bus_start();
    put_byte({OWN, 1'b1}, a2);
    get_byte(1'b0, b0);
    chk("R7 no stop before repeated start", n_stop - p0, 0);
    chk("R7 two starts", n_start - s0, 2);
    chk("R7 address ack after repeated start", int'(a2), 0);
    chk("R7 write byte before restart", int'(rx_log[r0[3:0]]), 8'hC3);
    chk("R7 read byte after restart", int'(b0), 8'h5A);
    bus_stop();
    tx_en = 1'b0;
  endtask

  task automatic t_low_toggle();
    int s0 = n_start, p0 = n_stop;
    scl_m = 1'b0; wq(1);
    sda_m = 1'b0; wq(2);
    sda_m = 1'b1; wq(2);
    scl_m = 1'b1; wq(2);
    chk("R1 no start from SDA edge with SCL low", n_start - s0, 0);
    chk("R1 no stop from SDA edge with SCL low", n_stop - p0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) tx_src[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    wq(2);
    t_write_own();
    t_other_addr();
    t_read();
    t_fill();
    t_restart();
    t_low_toggle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule